// File: doc/BRIEF.md
# Row Tag Buffer for a DRAM Cache

This block resolves tag lookups for a hardware-managed DRAM cache whose tags live inside the DRAM itself. Each DRAM row stores a tag group next to its cached blocks. The group holds one tag and one valid bit per block slot. Keeping every tag on chip would need a large SRAM. Instead, a small on-chip buffer keeps the whole tag group of a few recently used rows, one buffer entry per row.

A request names a row and a tag. If the row's group is already buffered, the block reports hit or miss, and the matching slot, without touching DRAM. If it is not buffered, the block picks a victim entry. A victim that holds updated tags is first written back to its row's tag area. The block then reads the requested row's tag group from DRAM, installs it and resolves the request. A fill request writes a new tag into a chosen slot of the buffered copy and marks that entry dirty. While the block is working on a request it holds its ready output low.

Top module: `rtb_tag_buffer`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, `md_req` is 0 and the buffer holds no row, so the first lookup of any row causes a metadata read.
- R2: Tag group encoding: slot w occupies bits [w*(TAG_W+1) +: TAG_W+1] of the group. The top bit of the slice is the valid bit and the lower TAG_W bits are the tag. A lookup hits when a valid slot's tag equals `req_tag`, and `res_way` gives that slot. If several slots match, the lowest-numbered slot wins. A slot whose valid bit is 0 never matches.
- R3: A lookup whose row is buffered makes no metadata access. Its result appears two cycles after the accepting clock edge, and a tag absent from the group reports `res_hit`=0.
- R4: A lookup whose row is not buffered issues exactly one metadata read of that row. It resolves against the returned group and installs it, so later requests to that row are buffer hits.
- R5: `req_ready` is low from the edge that accepts a request until the result is reported, including the whole time a metadata access is outstanding.
- R6: Once `md_req` is raised, `md_row`, `md_we` and `md_wdata` stay stable until the `md_done` pulse.
- R7: A fill request (`req_fill`=1) with `req_way` < WAYS sets that slot's valid bit and tag in the buffered group and marks the entry dirty, without an immediate DRAM write. It reports `res_hit`=1 with `res_way`=`req_way`. A fill with `req_way` >= WAYS changes nothing and reports `res_hit`=0.
- R8: The buffer holds up to ENTRIES rows. When a new row must be installed, an empty entry (lowest index first) is used. If every entry is full, the least recently used entry is replaced.
- R9: A dirty victim is written back (`md_we`=1, the victim's row, its buffered group) before the read of the new row starts. A clean victim is dropped with no write.
- R10: Each accepted request produces exactly one `res_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_row | input | ROW_W | DRAM row of the request |
| req_tag | input | TAG_W | Tag to look up or install |
| req_fill | input | 1 | 1 = install tag into a slot, 0 = lookup |
| req_way | input | WAY_W | Slot written by a fill |
| md_req | output | 1 | Metadata access request toward DRAM |
| md_we | output | 1 | 1 = write tag group, 0 = read |
| md_row | output | ROW_W | Row whose tag area is accessed |
| md_wdata | output | WAYS*(TAG_W+1) | Tag group to write |
| md_done | input | 1 | One-cycle completion pulse from DRAM |
| md_rdata | input | WAYS*(TAG_W+1) | Tag group read, valid with md_done |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Cache hit (lookup) or fill applied |
| res_way | output | WAY_W | Matching or written slot |

## Verification
The bench builds the block with ENTRIES=4, ROW_W=6, TAG_W=12 and WAYS=3, and gives its DRAM model a latency of three cycles. With only four buffer entries, a handful of distinct rows is enough to fill the buffer, force a least-recently-used choice and evict an entry made dirty by a fill. The three-slot groups leave room for an invalid slot carrying a matching tag, for two matching slots, and for an out-of-range fill slot. The six-bit row width keeps the DRAM model at 64 rows.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB_RD,
    ST_WB,
    ST_FETCH,
    ST_RESOLVE
  } rtb_state_e;
endpackage

// File: rtl/rtb_way_cmp.sv
// Compares one tag against every slot of a row's tag group; lowest slot wins.
module rtb_way_cmp #(
  parameter int TAG_W = 12,
  parameter int WAYS  = 3,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SL_W  = TAG_W + 1,
  localparam int GRP_W = WAYS * SL_W
) (
  input  logic [GRP_W-1:0] grp,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic [WAY_W-1:0] way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_slot
    assign match[w] = grp[w*SL_W + TAG_W] && (grp[w*SL_W +: TAG_W] == tag);
  end

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/rtb_row_dir.sv
// Row directory: which DRAM row each buffer entry holds, plus valid and dirty flags.
module rtb_row_dir #(
  parameter int ROW_W   = 10,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ROW_W-1:0]   lk_row,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  input  logic               inst_en,
  input  logic               mark_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [ROW_W-1:0]   inst_row,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic [ROW_W-1:0]   sel_row,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] dirty_vec
);
  logic [ROW_W-1:0]   rows [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign match[e] = valid_vec[e] && (rows[e] == lk_row);
  end

  always_comb begin
    lk_hit = |match;
    lk_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) lk_idx = IDX_W'(e);
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) rows[upd_idx] <= inst_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
      dirty_vec <= '0;
    end else if (inst_en) begin
      valid_vec[upd_idx] <= 1'b1;
      dirty_vec[upd_idx] <= 1'b0;
    end else if (mark_en) begin
      dirty_vec[upd_idx] <= 1'b1;
    end
  end

  assign sel_row = rows[sel_idx];
endmodule

// File: rtl/rtb_lru.sv
// Age-based LRU: ages stay a permutation of 0..ENTRIES-1; age 0 is most recent.
module rtb_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] age [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) age[j] <= IDX_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == touch_idx) age[j] <= '0;
        else if (age[j] < age[touch_idx]) age[j] <= age[j] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (!found && !valid_vec[j]) begin
        found  = 1'b1;
        victim = IDX_W'(j);
      end
    end
    if (!found) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (age[j] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/rtb_grp_mem.sv
// Simple dual-port memory with registered read, suitable for block RAM.
module rtb_grp_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 39,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtb_tag_buffer.sv
module rtb_tag_buffer #(
  parameter int ROW_W   = 10,
  parameter int TAG_W   = 12,
  parameter int WAYS    = 3,
  parameter int ENTRIES = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SL_W   = TAG_W + 1,
  localparam int GRP_W  = WAYS * SL_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_fill,
  input  logic [WAY_W-1:0] req_way,
  output logic             md_req,
  output logic             md_we,
  output logic [ROW_W-1:0] md_row,
  output logic [GRP_W-1:0] md_wdata,
  input  logic             md_done,
  input  logic [GRP_W-1:0] md_rdata,
  output logic             res_valid,
  output logic             res_hit,
  output logic [WAY_W-1:0] res_way
);
  import rtb_pkg::*;

  rtb_state_e       state;
  logic [ROW_W-1:0] row_r;
  logic [TAG_W-1:0] tag_r;
  logic             fill_r;
  logic [WAY_W-1:0] way_r;
  logic [IDX_W-1:0] ent_r;
  logic             use_mem;
  logic [GRP_W-1:0] fetch_r;

  logic               dir_hit;
  logic [IDX_W-1:0]   dir_idx;
  logic [ROW_W-1:0]   sel_row;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] dirty_vec;
  logic [IDX_W-1:0]   victim;
  logic [GRP_W-1:0]   mem_q;
  logic [GRP_W-1:0]   grp_cur;
  logic [GRP_W-1:0]   grp_new;
  logic               cmp_hit;
  logic [WAY_W-1:0]   cmp_way;
  logic               fill_ok;
  logic               inst_en;
  logic               mark_en;
  logic               mem_we;
  logic [GRP_W-1:0]   mem_wdata;
  logic               mem_re;
  logic [IDX_W-1:0]   mem_raddr;

  assign req_ready = (state == ST_IDLE);
  assign grp_cur   = use_mem ? mem_q : fetch_r;
  assign fill_ok   = ({1'b0, way_r} < (WAY_W + 1)'(WAYS));

  always_comb begin
    grp_new = grp_cur;
    for (int w = 0; w < WAYS; w++) begin
      if (way_r == WAY_W'(w)) grp_new[w*SL_W +: SL_W] = {1'b1, tag_r};
    end
  end

  assign inst_en   = (state == ST_FETCH) && md_done;
  assign mark_en   = (state == ST_RESOLVE) && fill_r && fill_ok;
  assign mem_we    = inst_en || mark_en;
  assign mem_wdata = inst_en ? md_rdata : grp_new;
  assign mem_re    = (state == ST_LOOK);
  assign mem_raddr = dir_hit ? dir_idx : victim;

  rtb_row_dir #(.ROW_W(ROW_W), .ENTRIES(ENTRIES)) u_dir (
    .clk(clk), .rst(rst),
    .lk_row(row_r), .lk_hit(dir_hit), .lk_idx(dir_idx),
    .inst_en(inst_en), .mark_en(mark_en), .upd_idx(ent_r), .inst_row(row_r),
    .sel_idx(ent_r), .sel_row(sel_row),
    .valid_vec(valid_vec), .dirty_vec(dirty_vec)
  );

  rtb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(state == ST_RESOLVE), .touch_idx(ent_r),
    .valid_vec(valid_vec), .victim(victim)
  );

  rtb_grp_mem #(.DEPTH(ENTRIES), .DW(GRP_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ent_r), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
  );

  rtb_way_cmp #(.TAG_W(TAG_W), .WAYS(WAYS)) u_cmp (
    .grp(grp_cur), .tag(tag_r), .hit(cmp_hit), .way(cmp_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      row_r     <= '0;
      tag_r     <= '0;
      fill_r    <= 1'b0;
      way_r     <= '0;
      ent_r     <= '0;
      use_mem   <= 1'b0;
      fetch_r   <= '0;
      md_req    <= 1'b0;
      md_we     <= 1'b0;
      md_row    <= '0;
      md_wdata  <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_way   <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            row_r  <= req_row;
            tag_r  <= req_tag;
            fill_r <= req_fill;
            way_r  <= req_way;
            state  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (dir_hit) begin
            ent_r   <= dir_idx;
            use_mem <= 1'b1;
            state   <= ST_RESOLVE;
          end else begin
            ent_r   <= victim;
            use_mem <= 1'b0;
            if (valid_vec[victim] && dirty_vec[victim]) begin
              state <= ST_WB_RD;
            end else begin
              md_req <= 1'b1;
              md_we  <= 1'b0;
              md_row <= row_r;
              state  <= ST_FETCH;
            end
          end
        end
        ST_WB_RD: begin
          md_req   <= 1'b1;
          md_we    <= 1'b1;
          md_row   <= sel_row;
          md_wdata <= mem_q;
          state    <= ST_WB;
        end
        ST_WB: begin
          if (md_done) begin
            md_we  <= 1'b0;
            md_row <= row_r;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (md_done) begin
            md_req  <= 1'b0;
            fetch_r <= md_rdata;
            state   <= ST_RESOLVE;
          end
        end
        ST_RESOLVE: begin
          res_valid <= 1'b1;
          if (fill_r) begin
            res_hit <= fill_ok;
            res_way <= way_r;
          end else begin
            res_hit <= cmp_hit;
            res_way <= cmp_way;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtb_checker.sv
module rtb_checker #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             md_req,
  input logic             md_we,
  input logic [ROW_W-1:0] md_row,
  input logic             md_done,
  input logic             res_valid
);
  // R5: no request accepted while a metadata access is outstanding
  a_r5_stall_on_md: assert property (@(posedge clk) disable iff (rst)
    md_req |-> !req_ready);

  // R5: accepting a request drops ready on the next cycle
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R10: result is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R6: metadata request held stable until completion
  a_r6_md_hold: assert property (@(posedge clk) disable iff (rst)
    (md_req && !md_done) |=> (md_req && $stable(md_row) && $stable(md_we)));

  // R9: a completed write-back is followed directly by the row read
  a_r9_wb_then_read: assert property (@(posedge clk) disable iff (rst)
    (md_req && md_we && md_done) |=> (md_req && !md_we));
endmodule

bind rtb_tag_buffer rtb_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .md_req(md_req), .md_we(md_we), .md_row(md_row), .md_done(md_done),
  .res_valid(res_valid)
);

// File: tb/sim_rtb_tag_buffer.sv
`timescale 1ns/1ps
module sim_rtb_tag_buffer;
  localparam int ROW_W = 6;
  localparam int TAG_W = 12;
  localparam int WAYS = 3;
  localparam int ENTRIES = 4;
  localparam int WAY_W = 2;
  localparam int GRP_W = WAYS * (TAG_W + 1);
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_fill = 1'b0;
  logic [WAY_W-1:0] req_way = '0;
  logic md_req, md_we;
  logic [ROW_W-1:0] md_row;
  logic [GRP_W-1:0] md_wdata;
  logic md_done = 1'b0;
  logic [GRP_W-1:0] md_rdata = '0;
  logic res_valid, res_hit;
  logic [WAY_W-1:0] res_way;

  always #10 clk = ~clk;

  rtb_tag_buffer #(.ROW_W(ROW_W), .TAG_W(TAG_W), .WAYS(WAYS), .ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_tag(req_tag), .req_fill(req_fill), .req_way(req_way),
    .md_req(md_req), .md_we(md_we), .md_row(md_row), .md_wdata(md_wdata),
    .md_done(md_done), .md_rdata(md_rdata),
    .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way)
  );

  int checks = 0;
  int fails = 0;
  int reads = 0;
  int writes = 0;
  int proto_bad = 0;
  int stall_bad = 0;
  int pulse_bad = 0;
  int nops = 0;
  logic log_we [64];
  logic [ROW_W-1:0] log_row [64];
  logic [GRP_W-1:0] dram [64];
  int cnt = 0;
  logic [ROW_W-1:0] row_h;
  logic we_h;

  function automatic logic [GRP_W-1:0] mkgrp(input logic v0, input logic [TAG_W-1:0] t0,
                                              input logic v1, input logic [TAG_W-1:0] t1,
                                              input logic v2, input logic [TAG_W-1:0] t2);
    return {v2, t2, v1, t1, v0, t0};
  endfunction

  // DRAM metadata model with fixed latency
  always @(negedge clk) begin
    if (rst) begin
      md_done = 1'b0;
      cnt = 0;
    end else if (md_done) begin
      md_done = 1'b0;
    end else if (md_req) begin
      if (cnt == 0) begin
        row_h = md_row;
        we_h = md_we;
      end else if (md_row != row_h || md_we != we_h) begin
        proto_bad++;
      end
      if (cnt == LAT) begin
        cnt = 0;
        md_done = 1'b1;
        if (nops < 64) begin
          log_we[nops] = md_we;
          log_row[nops] = md_row;
        end
        nops++;
        if (md_we) begin
          dram[md_row] = md_wdata;
          writes++;
        end else begin
          md_rdata = dram[md_row];
          reads++;
        end
      end else begin
        cnt++;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic run_req(input logic [ROW_W-1:0] row, input logic [TAG_W-1:0] tag,
                         input logic fill, input logic [WAY_W-1:0] way,
                         output logic hit, output logic [WAY_W-1:0] wo, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_row = row;
    req_tag = tag;
    req_fill = fill;
    req_way = way;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 2000) begin
      if (req_ready) stall_bad++;
      @(negedge clk);
      lat++;
    end
    hit = res_hit;
    wo = res_way;
    @(negedge clk);
    if (res_valid) pulse_bad++;
  endtask

  task automatic t_reset();
    check("R1 ready after reset", req_ready, 1);
    check("R1 res_valid after reset", res_valid, 0);
    check("R1 md_req after reset", md_req, 0);
  endtask

  task automatic t_cold();
    logic h; logic [WAY_W-1:0] w; int l;
    run_req(6'd5, 12'hABC, 0, 0, h, w, l);
    check("R2 hit skips invalid slot", h, 1);
    check("R2 way of match", w, 1);
    check("R4 one read on buffer miss", reads, 1);
    check("R1 first lookup fetched", writes, 0);
    run_req(6'd5, 12'h123, 0, 0, h, w, l);
    check("R3 buffered hit way", w, 2);
    check("R3 buffered hit latency", l, 2);
    check("R4 installed row no reread", reads, 1);
    run_req(6'd5, 12'h777, 0, 0, h, w, l);
    check("R3 absent tag misses", h, 0);
    check("R3 miss no metadata access", reads, 1);
  endtask

  task automatic t_dup();
    logic h; logic [WAY_W-1:0] w; int l;
    run_req(6'd6, 12'h055, 0, 0, h, w, l);
    check("R2 duplicate hit", h, 1);
    check("R2 lowest slot wins", w, 0);
    check("R4 second row read", reads, 2);
  endtask

  task automatic t_fill();
    logic h; logic [WAY_W-1:0] w; int l;
    run_req(6'd5, 12'h321, 1, 0, h, w, l);
    check("R7 fill result hit", h, 1);
    check("R7 fill result way", w, 0);
    check("R7 no immediate write", writes, 0);
    run_req(6'd5, 12'h321, 0, 0, h, w, l);
    check("R7 filled tag hits", h, 1);
    check("R7 filled tag way", w, 0);
    check("R7 no read after fill", reads, 2);
    run_req(6'd5, 12'h111, 1, 3, h, w, l);
    check("R7 out of range slot rejected", h, 0);
    run_req(6'd5, 12'h111, 0, 0, h, w, l);
    check("R7 out of range slot left no tag", h, 0);
  endtask

  task automatic t_lru();
    logic h; logic [WAY_W-1:0] w; int l;
    run_req(6'd7, 12'h001, 0, 0, h, w, l);
    run_req(6'd8, 12'h001, 0, 0, h, w, l);
    check("R8 empty entries used", reads, 4);
    run_req(6'd9, 12'h001, 0, 0, h, w, l);
    check("R8 full buffer evicts", reads, 5);
    check("R9 clean victim no write", writes, 0);
    run_req(6'd5, 12'h321, 0, 0, h, w, l);
    check("R8 recent row kept", reads, 5);
    check("R8 recent row hit", h, 1);
    run_req(6'd6, 12'h055, 0, 0, h, w, l);
    check("R8 LRU row was evicted", reads, 6);
  endtask

  task automatic t_wb();
    logic h; logic [WAY_W-1:0] w; int l;
    run_req(6'd10, 12'h001, 0, 0, h, w, l);
    check("R9 clean eviction", writes, 0);
    run_req(6'd9, 12'h001, 0, 0, h, w, l);
    run_req(6'd6, 12'h001, 0, 0, h, w, l);
    run_req(6'd10, 12'h001, 0, 0, h, w, l);
    check("R8 hits on resident rows", reads, 7);
    run_req(6'd11, 12'h001, 0, 0, h, w, l);
    check("R9 dirty victim written", writes, 1);
    check("R9 read after write-back", reads, 8);
    check("R9 write-back op first", log_we[nops-2], 1);
    check("R9 write-back row", log_row[nops-2], 5);
    check("R9 fetch row", log_row[nops-1], 11);
    check("R9 write-back data", dram[5], mkgrp(1, 12'h321, 1, 12'hABC, 1, 12'h123));
    run_req(6'd5, 12'h321, 0, 0, h, w, l);
    check("R7 filled tag survives eviction", h, 1);
    check("R4 re-read evicted row", reads, 9);
    check("R9 refetched row clean", writes, 1);
  endtask

  task automatic t_proto();
    check("R5 ready low while busy", stall_bad, 0);
    check("R10 single result pulse", pulse_bad, 0);
    check("R6 metadata request stable", proto_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) dram[i] = '0;
    dram[5] = mkgrp(0, 12'hABC, 1, 12'hABC, 1, 12'h123);
    dram[6] = mkgrp(1, 12'h055, 0, 12'h000, 1, 12'h055);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold();
    t_dup();
    t_fill();
    t_lru();
    t_wb();
    t_proto();
    summary();
    $finish;
  end
endmodule